// File: doc/BRIEF.md
# Constant-Time Binary Field Inverter

This block computes the multiplicative inverse of an element of GF(2^M) for a field polynomial given at run time. It runs a binary extended Euclidean iteration in the style of Berlekamp. Two polynomials are kept aligned on their top coefficient, and two cofactor registers follow them. A small up/down counter tracks how far apart the degrees of the two working polynomials are. Each iteration either shifts the first polynomial left or cancels the leading term of the second against it. The counter's value selects between swapping the pair and dividing a cofactor by x.

The number of iterations is always 2M, whatever the operand. One extra cycle registers the result, so every inversion takes exactly 2M+1 cycles. Because the run time does not depend on the data, the block leaks no timing information, and it is cheap enough that affine point arithmetic remains attractive. A zero operand has no inverse. The block flags it and still takes the full time.

Top module: `gf2m_inverter`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and result_o is zero.
- R2: start_i is sampled only while busy_o is low. On that edge operand_i and poly_i are captured, busy_o is high from the next cycle until the result is delivered, and later changes on the inputs have no effect on the run.
- R3: done_o is a one-cycle pulse that rises exactly 2M+1 rising edges after the edge that sampled start_i, for every operand. busy_o falls in the same cycle that done_o rises.
- R4: For a nonzero operand a, the value on result_o while done_o is high satisfies a·result ≡ 1 modulo the field polynomial, and err_o is low.
- R5: poly_i holds the coefficients of x^0..x^(M-1) of the field polynomial (bit i is the coefficient of x^i), and the x^M term is implied. Any irreducible polynomial given this way is handled.
- R6: A zero operand gives err_o high and result_o zero at done_o, with the same 2M+1-cycle latency.
- R7: A start_i pulse while busy_o is high is ignored. The running inversion keeps its timing and its result.
- R8: result_o and err_o change only in a cycle where done_o is high, and they hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new inversion (sampled while idle) |
| operand_i | input | M | Element to invert, bit i = coefficient of x^i |
| poly_i | input | M | Low M coefficients of the field polynomial |
| busy_o | output | 1 | Inversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Operand was zero |
| result_o | output | M | Inverse, valid from done_o |

## Verification
The result, the error flag and the completion pulse are all due on the 2M+1-th rising edge after the edge that accepts start_i. busy_o is due on the first edge after it. The bench drives and samples on falling edges and counts each falling edge from the acceptance. It requires done_o to be low and busy_o high on every cycle before the due cycle, and done_o high with busy_o low exactly on it. It checks the products and flags in the due cycle, and checks that done_o is low again on the following cycle.

// File: rtl/gf2m_inv_pkg.sv
`timescale 1ns/1ps
package gf2m_inv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } inv_state_e;
endpackage

// File: rtl/gf2m_inv_step.sv
`timescale 1ns/1ps
// One Euclidean iteration: top-aligned polynomials r/s, cofactors u/v.
module gf2m_inv_step #(
  parameter int M  = 8,
  parameter int DW = 5
) (
  input  logic [M:0]    r_i,
  input  logic [M:0]    s_i,
  input  logic [M:0]    u_i,
  input  logic [M:0]    v_i,
  input  logic [DW-1:0] dlt_i,
  output logic [M:0]    r_o,
  output logic [M:0]    s_o,
  output logic [M:0]    u_o,
  output logic [M:0]    v_o,
  output logic [DW-1:0] dlt_o
);
  logic [M:0] s_red, v_red;

  always_comb begin
    s_red = s_i[M] ? (s_i ^ r_i) : s_i;
    v_red = s_i[M] ? (v_i ^ u_i) : v_i;
    r_o   = r_i;
    s_o   = s_i;
    u_o   = u_i;
    v_o   = v_i;
    dlt_o = dlt_i;
    if (!r_i[M]) begin
      r_o   = r_i << 1;
      u_o   = u_i << 1;
      dlt_o = dlt_i + 1'b1;
    end else if (dlt_i == '0) begin
      // swap roles; leading term of s already cancelled
      r_o   = s_red << 1;
      s_o   = r_i;
      u_o   = v_red << 1;
      v_o   = u_i;
      dlt_o = DW'(1);
    end else begin
      s_o   = s_red << 1;
      v_o   = v_red;
      u_o   = u_i >> 1;
      dlt_o = dlt_i - 1'b1;
    end
  end
endmodule

// File: rtl/gf2m_inv_ctrl.sv
`timescale 1ns/1ps
module gf2m_inv_ctrl
  import gf2m_inv_pkg::*;
#(
  parameter int M = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);
  localparam int STEPS = 2 * M;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  inv_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fin_o  = (state_q == ST_FIN);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == CW'(STEPS - 1)) state_q <= ST_FIN;
          else                         cnt_q   <= cnt_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf2m_inverter.sv
`timescale 1ns/1ps
module gf2m_inverter #(
  parameter int M = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] operand_i,
  input  logic [M-1:0] poly_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o,
  output logic [M-1:0] result_o
);
  localparam int DW = $clog2(2 * M + 1) + 1;

  logic          load, step, fin;
  logic [M:0]    r_q, s_q, u_q, v_q;
  logic [M:0]    r_n, s_n, u_n, v_n;
  logic [DW-1:0] dlt_q, dlt_n;
  logic          zero_q;

  gf2m_inv_ctrl #(.M(M)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin),
    .busy_o (busy_o)
  );

  gf2m_inv_step #(.M(M), .DW(DW)) u_step (
    .r_i  (r_q),
    .s_i  (s_q),
    .u_i  (u_q),
    .v_i  (v_q),
    .dlt_i(dlt_q),
    .r_o  (r_n),
    .s_o  (s_n),
    .u_o  (u_n),
    .v_o  (v_n),
    .dlt_o(dlt_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q    <= '0;
      s_q    <= '0;
      u_q    <= '0;
      v_q    <= '0;
      dlt_q  <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      r_q    <= {1'b0, operand_i};
      s_q    <= {1'b1, poly_i};
      u_q    <= (M + 1)'(1);
      v_q    <= '0;
      dlt_q  <= '0;
      zero_q <= (operand_i == '0);
    end else if (step) begin
      r_q    <= r_n;
      s_q    <= s_n;
      u_q    <= u_n;
      v_q    <= v_n;
      dlt_q  <= dlt_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        err_o    <= zero_q;
        result_o <= zero_q ? '0 : u_q[M-1:0];
      end
    end
  end
endmodule

// File: rtl/gf2m_inverter_chk.sv
`timescale 1ns/1ps
module gf2m_inverter_chk #(
  parameter int M = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         err_o,
  input logic [M-1:0] result_o
);
  logic [15:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat_q <= '0;
    else if (start_i && !busy_o)  lat_q <= 16'd1;
    else if (busy_o)              lat_q <= lat_q + 16'd1;
  end

  // R3
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == 16'(2 * M + 2));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  busy_until_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(result_o) && $stable(err_o)) |-> done_o);

  // R6
  zero_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> result_o == '0);
endmodule

bind gf2m_inverter gf2m_inverter_chk #(.M(M)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .result_o(result_o)
);

// File: tb/sim_gf2m_inverter.sv
`timescale 1ns/1ps
module sim_gf2m_inverter;
  localparam int W = 8;
  localparam logic [W-1:0] POLY_A = 8'h1B; // x^8+x^4+x^3+x+1
  localparam logic [W-1:0] POLY_B = 8'h1D; // x^8+x^4+x^3+x^2+1

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] operand = '0;
  logic [W-1:0] poly = '0;
  logic         busy, done, err;
  logic [W-1:0] result;
  int           n_chk = 0;
  int           n_err = 0;

  always #5 clk = ~clk;

  gf2m_inverter #(.M(W)) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .operand_i(operand),
    .poly_i   (poly),
    .busy_o   (busy),
    .done_o   (done),
    .err_o    (err),
    .result_o (result)
  );

  function automatic logic [W-1:0] gmul(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] p);
    logic [W-1:0] acc = '0;
    logic [W-1:0] aa = a;
    for (int i = 0; i < W; i++) begin
      if (b[i]) acc ^= aa;
      aa = aa[W-1] ? ((aa << 1) ^ p) : (aa << 1);
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_inv(input logic [W-1:0] op, input logic [W-1:0] pl, input bit intrude, input string req);
    bit early = 0;
    logic [W-1:0] prod;
    @(negedge clk);
    start = 1'b1; operand = op; poly = pl;
    @(negedge clk);
    start = 1'b0; operand = ~op; poly = ~pl;   // R2: inputs after capture are don't-care
    chk(busy === 1'b1, "R2 busy after start", 32'(busy), 1);
    for (int k = 1; k <= 2 * W + 1; k++) begin
      if (intrude && k == 3) begin start = 1'b1; operand = op ^ 8'h5A; end
      @(negedge clk);
      start = 1'b0;
      if (k < 2 * W + 1 && (done !== 1'b0 || busy !== 1'b1)) early = 1;
    end
    chk(!early && done === 1'b1 && busy === 1'b0, intrude ? "R7 latency" : "R3 latency",
        {early, done, busy}, 32'b010);
    if (op == '0) begin
      chk(err === 1'b1 && result === '0, "R6 zero operand", {err, result}, {1'b1, 8'h00});
    end else begin
      prod = gmul(result, op, pl);
      chk(err === 1'b0 && prod === 8'h01, req, {err, prod}, 32'h1);
    end
    @(negedge clk);
    chk(done === 1'b0, "R3 pulse width", 32'(done), 0);
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R1
    chk(busy === 0 && done === 0 && err === 0 && result === '0, "R1 reset state",
        {busy, done, err, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && done === 0, "R1 idle after reset", {busy, done}, 0);

    // R4: sweep all nonzero operands
    for (int a = 1; a < 256; a++) run_inv(8'(a), POLY_A, 1'b0, "R4 inverse");
    // R5: second polynomial
    for (int a = 1; a < 256; a++) run_inv(8'(a), POLY_B, 1'b0, "R5 other poly");

    // R6: zero operand, then R8 clear on next good run
    run_inv(8'h00, POLY_A, 1'b0, "R6");
    run_inv(8'h53, POLY_A, 1'b0, "R8 err cleared");

    // R7: start while busy ignored
    run_inv(8'h02, POLY_A, 1'b1, "R7 result kept");
    run_inv(8'hFF, POLY_B, 1'b1, "R7 result kept");

    // R8: outputs hold with input activity but no start
    held = result;
    for (int k = 0; k < 6; k++) begin
      operand = 8'(k * 37); poly = 8'(k * 11);
      @(negedge clk);
      chk(result === held && done === 0 && busy === 0, "R8 hold", {busy, done, result}, {2'b00, held});
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule